// File: doc/BRIEF.md
# Monitor Status and Control Register File

This block is the register file of an on-chip monitoring unit. A synchronous request port reaches 128 words of 16 bits. The port has a 7-bit address, write data, read data, an enable, a write strobe and a one-cycle ready reply. The lower 64 words are status and cannot be written from the port. They hold conversion results and calibration coefficients, which a separate result port loads. They also hold the running extremes of three on-chip sensors and a live flag word. The upper 64 words hold configuration, sequence and alarm settings. Only the first 24 of these words exist. Their reset values are a design-time parameter.

Each time the result port writes a new reading for one of the three tracked sensors, the block compares it with that sensor's stored peak and trough. It updates them in the same clock edge. A reset clears both to states that the first reading always replaces. Results are kept left-aligned: only the upper RES_BITS bits of a reading are stored.

Top module: `mon_regfile`

## Requirements
- R1: After reset, control word 40h+i (i = 0..23) reads 0000h for i = 3..7 and 5A00h OR i for every other i.
- R2: busReady is high in exactly the cycles that follow a cycle with busEn high. busRdData is valid while busReady is high.
- R3: A port write to 40h..57h replaces that word, and a later read returns the written value.
- R4: Port writes to 00h..3Fh leave the status words unchanged but are still acknowledged. Every write cycle returns 0000h on busRdData.
- R5: Addresses 58h..7Fh read 0000h. Writes to them change no defined word.
- R6: A result-port write to status address a stores resData with its lower 16-RES_BITS bits cleared (default: low 6 bits). A read of a returns that value. Result-port writes to 20h..27h and 3Fh are ignored.
- R7: Words 20h, 21h and 22h hold the largest stored result written to 00h, 01h and 02h respectively since reset.
- R8: Words 24h, 25h and 26h hold the smallest stored result written to 00h, 01h and 02h respectively since reset.
- R9: Reset sets every status word to 0000h, except 24h..26h, which are set to FFC0h. This holds even after earlier activity.
- R10: Word 3Fh reads {13'b0, intRefUsed, monDisabled, overTemp} (bit 0 over-temperature, bit 1 disabled, bit 2 internal reference), sampled in the enable cycle.
- R11: A port read in the same cycle as a result write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Port access request, one cycle per access |
| busWe | input | 1 | Write strobe, qualified by busEn |
| busAddr | input | 7 | Word address |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid with busReady |
| busReady | output | 1 | One-cycle reply, the cycle after busEn |
| resWe | input | 1 | Result-port write strobe |
| resAddr | input | 6 | Status address of the result |
| resData | input | 16 | Result word, left-aligned |
| overTemp | input | 1 | Over-temperature status for the flag word |
| monDisabled | input | 1 | Disabled indication for the flag word |
| intRefUsed | input | 1 | Internal-reference-in-use indication |

## Verification
The hardest case to reach from the ports is the extreme tracker racing a port read. Here the result port updates a peak in the same edge that latches a read of that peak. The bench builds this case on purpose and expects the old value, then the new value on the next read. Peaks and troughs are driven with a modular-arithmetic sequence whose values rise and fall. The bench keeps its own running extremes and compares them with every status word. A reset in mid-run shows that the extremes return to their starting states.

// File: rtl/mon_regfile_pkg.sv
package mon_regfile_pkg;

  localparam int CTRL_COUNT = 24;
  localparam int TEST_FIRST = 3;
  localparam int TEST_LAST  = 7;
  localparam int MAX_BASE   = 'h20;
  localparam int MIN_BASE   = 'h24;
  localparam int GUARD_LAST = 'h27;
  localparam int FLAG_ADDR  = 'h3F;

  typedef struct packed {
    logic access;
    logic ctrlWr;
    logic selStatus;
    logic selCtrl;
  } busStrobe_t;

  function automatic logic [CTRL_COUNT-1:0][15:0] defaultInit();
    logic [CTRL_COUNT-1:0][15:0] v;
    for (int i = 0; i < CTRL_COUNT; i++) begin
      if (i >= TEST_FIRST && i <= TEST_LAST) v[i] = 16'h0000;
      else v[i] = 16'h5A00 | 16'(i);
    end
    return v;
  endfunction

  localparam logic [CTRL_COUNT-1:0][15:0] DEFAULT_INIT = defaultInit();

endpackage

// File: rtl/mon_regfile_ctrl.sv
module mon_regfile_ctrl
  import mon_regfile_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb,
  output logic              busReady
);

  localparam int LOW_W = ADDR_W - 1;

  logic upperHalf;
  logic defined;

  assign upperHalf = busAddr[ADDR_W-1];
  assign defined   = int'(busAddr[LOW_W-1:0]) < CTRL_COUNT;

  always_comb begin
    strb.access    = busEn;
    strb.ctrlWr    = busEn && busWe && upperHalf && defined;
    strb.selStatus = busEn && !busWe && !upperHalf;
    strb.selCtrl   = busEn && !busWe && upperHalf && defined;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busEn;
  end

  assert_ready_after_en_R2: assert property (@(posedge clk) disable iff (!rstN)
    busEn |=> busReady);
  assert_no_spurious_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !busReady);

endmodule

// File: rtl/mon_regfile_dp.sv
module mon_regfile_dp
  import mon_regfile_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 7,
  parameter int RES_BITS    = 10,
  parameter int NUM_TRACKED = 3,
  parameter logic [CTRL_COUNT-1:0][15:0] CTRL_INIT = DEFAULT_INIT
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              resWe,
  input  logic [ADDR_W-2:0] resAddr,
  input  logic [DATA_W-1:0] resData,
  input  logic              overTemp,
  input  logic              monDisabled,
  input  logic              intRefUsed
);

  localparam int STATUS_N = 1 << (ADDR_W - 1);
  localparam int CIDX_W   = $clog2(CTRL_COUNT);
  localparam logic [DATA_W-1:0] RES_MASK = ~((DATA_W'(1) << (DATA_W - RES_BITS)) - DATA_W'(1));

  logic [DATA_W-1:0] statusMem [STATUS_N];
  logic [DATA_W-1:0] ctrlMem   [CTRL_COUNT];
  logic [DATA_W-1:0] maskedRes;
  logic [DATA_W-1:0] statusView;
  logic [DATA_W-1:0] flagWord;
  logic              guarded;
  logic [CIDX_W-1:0] ctrlIdx;
  logic [ADDR_W-2:0] statIdx;

  assign maskedRes = resData & RES_MASK;
  assign guarded   = (int'(resAddr) >= MAX_BASE && int'(resAddr) <= GUARD_LAST)
                     || int'(resAddr) == FLAG_ADDR;
  assign ctrlIdx   = busAddr[CIDX_W-1:0];
  assign statIdx   = busAddr[ADDR_W-2:0];
  assign flagWord  = {{(DATA_W-3){1'b0}}, intRefUsed, monDisabled, overTemp};
  assign statusView = (int'(statIdx) == FLAG_ADDR) ? flagWord : statusMem[statIdx];

  // status store and extreme tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STATUS_N; i++) statusMem[i] <= '0;
      for (int t = 0; t < NUM_TRACKED; t++) statusMem[MIN_BASE+t] <= RES_MASK;
    end else if (resWe) begin
      if (!guarded) statusMem[resAddr] <= maskedRes;
      for (int t = 0; t < NUM_TRACKED; t++) begin
        if (int'(resAddr) == t) begin
          if (maskedRes > statusMem[MAX_BASE+t]) statusMem[MAX_BASE+t] <= maskedRes;
          if (maskedRes < statusMem[MIN_BASE+t]) statusMem[MIN_BASE+t] <= maskedRes;
        end
      end
    end
  end

  // control store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CTRL_COUNT; i++) ctrlMem[i] <= DATA_W'(CTRL_INIT[i]);
    end else if (strb.ctrlWr) begin
      ctrlMem[ctrlIdx] <= busWrData;
    end
  end

  // registered read data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdData <= '0;
    else if (strb.access) begin
      if (strb.selStatus)    busRdData <= statusView;
      else if (strb.selCtrl) busRdData <= ctrlMem[ctrlIdx];
      else                   busRdData <= '0;
    end
  end

  for (genvar g = 0; g < NUM_TRACKED; g++) begin : g_track
    assert_max_monotonic_R7: assert property (@(posedge clk) disable iff (!rstN)
      statusMem[MAX_BASE+g] >= $past(statusMem[MAX_BASE+g]));
    assert_min_monotonic_R8: assert property (@(posedge clk) disable iff (!rstN)
      statusMem[MIN_BASE+g] <= $past(statusMem[MIN_BASE+g]));
  end

  assert_ctrl_write_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> ctrlMem[$past(ctrlIdx)] == $past(busWrData));

endmodule

// File: rtl/mon_regfile.sv
module mon_regfile
  import mon_regfile_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 7,
  parameter int RES_BITS    = 10,
  parameter int NUM_TRACKED = 3,
  parameter logic [CTRL_COUNT-1:0][15:0] CTRL_INIT = DEFAULT_INIT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busReady,
  input  logic              resWe,
  input  logic [ADDR_W-2:0] resAddr,
  input  logic [DATA_W-1:0] resData,
  input  logic              overTemp,
  input  logic              monDisabled,
  input  logic              intRefUsed
);

  busStrobe_t strb;

  mon_regfile_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .strb(strb), .busReady(busReady)
  );

  mon_regfile_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RES_BITS(RES_BITS),
    .NUM_TRACKED(NUM_TRACKED), .CTRL_INIT(CTRL_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .resWe(resWe), .resAddr(resAddr), .resData(resData),
    .overTemp(overTemp), .monDisabled(monDisabled), .intRefUsed(intRefUsed)
  );

  assert_undefined_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    busEn && !busWe && busAddr[ADDR_W-1] && int'(busAddr[ADDR_W-2:0]) >= CTRL_COUNT
    |=> busRdData == '0);
  assert_write_returns_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    busEn && busWe |=> busReady && busRdData == '0);

endmodule

// File: tb/mon_regfile_bench.sv
module mon_regfile_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        busReady;
  logic        resWe = 1'b0;
  logic [5:0]  resAddr = '0;
  logic [15:0] resData = '0;
  logic        overTemp = 1'b1, monDisabled = 1'b0, intRefUsed = 1'b1;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [15:0] modelStatus [64];
  logic [15:0] modelCtrl [24];

  mon_regfile u_mon_regfile (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busReady(busReady),
    .resWe(resWe), .resAddr(resAddr), .resData(resData),
    .overTemp(overTemp), .monDisabled(monDisabled), .intRefUsed(intRefUsed)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] initVal(input int i);
    return (i >= 3 && i <= 7) ? 16'h0000 : (16'h5A00 | 16'(i));
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) modelStatus[i] = 16'h0000;
    for (int i = 0; i < 3; i++) modelStatus['h24 + i] = 16'hFFC0;
    for (int i = 0; i < 24; i++) modelCtrl[i] = initVal(i);
  endtask

  function automatic logic [15:0] expected(input int a);
    if (a == 'h3F) return {13'b0, intRefUsed, monDisabled, overTemp};
    if (a < 64) return modelStatus[a];
    if (a < 64 + 24) return modelCtrl[a - 64];
    return 16'h0000;
  endfunction

  function automatic string tagFor(input int a);
    if (a == 'h3F) return "R10";
    if (a >= 'h20 && a <= 'h22) return "R7";
    if (a >= 'h24 && a <= 'h26) return "R8";
    if (a < 64) return "R6/R9";
    if (a < 88) return "R1/R3";
    return "R5";
  endfunction

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic busRead(input int a, output logic [15:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = 7'(a);
    @(negedge clk);
    busEn = 1'b0;
    check("R2 ready after read", {15'b0, busReady}, 16'h0001);
    d = busRdData;
  endtask

  task automatic busWrite(input int a, input logic [15:0] v);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = 7'(a); busWrData = v;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
    check("R4 write acknowledged", {15'b0, busReady}, 16'h0001);
    check("R4 write returns zero", busRdData, 16'h0000);
    if (a >= 64 && a < 88) modelCtrl[a - 64] = v;
  endtask

  task automatic resWrite(input int a, input logic [15:0] v);
    logic [15:0] m;
    m = v & 16'hFFC0;
    @(negedge clk);
    resWe = 1'b1; resAddr = 6'(a); resData = v;
    @(negedge clk);
    resWe = 1'b0;
    if (!((a >= 'h20 && a <= 'h27) || a == 'h3F)) modelStatus[a] = m;
    if (a < 3) begin
      if (m > modelStatus['h20 + a]) modelStatus['h20 + a] = m;
      if (m < modelStatus['h24 + a]) modelStatus['h24 + a] = m;
    end
  endtask

  task automatic sweepAll(input int lo, input int hi);
    logic [15:0] d;
    for (int a = lo; a <= hi; a++) begin
      busRead(a, d);
      check(tagFor(a), d, expected(a));
    end
  endtask

  initial begin
    logic [15:0] d;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle ready low", {15'b0, busReady}, 16'h0000);
    // reset contents across the whole map
    sweepAll(0, 127);
    // write every address through the port
    for (int a = 0; a < 128; a++) busWrite(a, 16'hC3A5 ^ (16'(a) * 16'h0101));
    @(negedge clk);
    check("R2 ready drops after write", {15'b0, busReady}, 16'h0000);
    sweepAll(0, 127);
    // results with rising and falling values, junk in low bits
    for (int k = 0; k < 12; k++)
      for (int ch = 0; ch < 3; ch++)
        resWrite(ch, 16'(((k * 37 + ch * 101 + (k % 3) * 400) % 1024) << 6) | 16'h0015);
    resWrite('h08, 16'hABCD);
    resWrite('h09, 16'h1234);
    resWrite('h10, 16'hFFFF);
    resWrite('h21, 16'h7777);
    resWrite('h24, 16'h0040);
    resWrite('h27, 16'h5555);
    resWrite('h3F, 16'hFFFF);
    sweepAll(0, 63);
    // flag inputs change
    overTemp = 1'b0; monDisabled = 1'b1; intRefUsed = 1'b0;
    busRead('h3F, d);
    check("R10 flag word", d, 16'h0002);
    // R11: read of peak in the same edge as a new peak
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b0; busAddr = 7'h20;
    resWe = 1'b1; resAddr = 6'h00; resData = 16'hFFC0;
    @(negedge clk);
    busEn = 1'b0; resWe = 1'b0;
    check("R11 old value on colliding read", busRdData, modelStatus['h20]);
    modelStatus['h00] = 16'hFFC0;
    modelStatus['h20] = 16'hFFC0;
    if (modelStatus['h24] > 16'hFFC0) modelStatus['h24] = 16'hFFC0;
    busRead('h20, d);
    check("R11 new value next read", d, 16'hFFC0);
    // reset after activity
    doReset();
    sweepAll(0, 127);
    // first result after reset sets both extremes
    resWrite(1, 16'h8000);
    busRead('h21, d);
    check("R7 first result sets max", d, 16'h8000);
    busRead('h25, d);
    check("R8 first result sets min", d, 16'h8000);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule